// File: doc/BRIEF.md
# Row SECDED Read Corrector

This block sits between a nonvolatile program memory and its readers. The memory stores data in rows of 64 bits. Each row carries one extra check byte, so a stored codeword is 72 bits wide. When a row is read, the block recomputes the parity, forms a syndrome and returns the row one clock later. Any single flipped bit in the codeword is repaired without the reader seeing it. A pair of flipped bits is detected, and that data is passed on unaltered. Whenever an error is seen, the block raises an interrupt pulse and sets one of two sticky flags. One flag is for repaired errors and one is for unrepairable errors. Software clears each flag by pulsing its clear input.

The same parity matrix also drives a combinational encoder. The write path uses it to produce the check byte for new data. When the enable input is low, checking is off. The check byte then behaves as plain extra storage: it is returned as read, and no flag or interrupt is raised.

Top module: `row_secded`

## Requirements
- R1: The encoder output `enc_check` has two parts. Bits [6:0] form the Hamming part. Data bit i is given position p(i), the i-th integer in 1..127 that is not a power of two, counting in ascending order. Bit k of the Hamming part is the XOR of every data bit whose position has bit k set. Bit 7 is chosen so that the 64 data bits plus all 8 check bits have even parity.
- R2: `out_valid` is high in the cycle after each cycle in which `rd_req` is high, and low otherwise. `out_data` and `out_check` belong to that read.
- R3: A read with checking enabled and an intact codeword returns the data unchanged. It raises no interrupt and sets no flag.
- R4: With checking enabled, a single flipped data bit is corrected in `out_data`. The read sets `flag_fixed`.
- R5: With checking enabled, a single flipped check bit leaves `out_data` equal to the stored data. This includes bit 7. The read still sets `flag_fixed`.
- R6: With checking enabled, two flipped bits anywhere in the codeword cause the raw data to be returned. The read sets `flag_unfixable` and leaves `flag_fixed` unchanged.
- R7: `err_irq` is a single-cycle pulse. It is high together with `out_valid` for each read that finds an error, and low in every other cycle.
- R8: The two flags stay set until their clear input is sampled high. If a new error and a clear for the same flag arrive at the same edge, the flag stays set.
- R9: With `ecc_on` low, `out_data` and `out_check` equal the stored values even when those values are corrupted. No interrupt is raised and neither flag changes.
- R10: `out_check` always returns the stored check byte as read, without correction.
- R11: After reset, `out_valid`, `err_irq`, both flags and `out_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ecc_on | input | 1 | Enables checking and correction |
| rd_req | input | 1 | A row is presented on the read inputs this cycle |
| rd_data | input | 64 | Stored data bits of the row |
| rd_check | input | 8 | Stored check byte of the row |
| out_valid | output | 1 | Read result valid |
| out_data | output | 64 | Corrected (or raw) row data |
| out_check | output | 8 | Stored check byte as read |
| err_irq | output | 1 | One-cycle pulse per read that found an error |
| flag_fixed | output | 1 | Sticky: a corrected error was seen |
| flag_unfixable | output | 1 | Sticky: an uncorrectable error was seen |
| clr_fixed | input | 1 | Clears `flag_fixed` |
| clr_unfixable | input | 1 | Clears `flag_unfixable` |
| enc_data | input | 64 | Data to be written |
| enc_check | output | 8 | Check byte for `enc_data` |

## Verification
The assertions check several properties on every cycle. The valid strobe follows the request by exactly one cycle. The interrupt only appears together with a valid result and a set flag. A flag never rises without an interrupt, and it stays set while no clear is applied. A disabled read passes its data through and raises nothing. Whether a given corruption is corrected, passed through or classed correctly can only be shown by the bench's scenarios. Those scenarios inject errors into chosen data bits, Hamming check bits, the overall parity bit and bit pairs, and the bench compares each result against its own model of the code.

// File: rtl/row_secded.sv
module row_secded #(
  parameter int DATA_W = 64,
  parameter int P      = 7,
  localparam int CHK_W = P + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ecc_on,
  input  logic              rd_req,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [CHK_W-1:0]  rd_check,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [CHK_W-1:0]  out_check,
  output logic              err_irq,
  output logic              flag_fixed,
  output logic              flag_unfixable,
  input  logic              clr_fixed,
  input  logic              clr_unfixable,
  input  logic [DATA_W-1:0] enc_data,
  output logic [CHK_W-1:0]  enc_check
);

  function automatic logic [P-1:0] dpos(input int idx);
    logic [P-1:0] r;
    int n;
    r = '0;
    n = 0;
    for (int p = 1; p < (1 << P); p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == idx) r = P'(p);
        n++;
      end
    end
    return r;
  endfunction

  logic [P-1:0] wr_term [DATA_W];
  logic [P-1:0] rd_term [DATA_W];
  logic [DATA_W-1:0] flip;
  logic [P-1:0] wr_ham, rd_ham, syn;
  logic odd, chk_only, fixed, unfix;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    localparam logic [P-1:0] POS = dpos(i);
    assign wr_term[i] = enc_data[i] ? POS : '0;
    assign rd_term[i] = rd_data[i]  ? POS : '0;
    assign flip[i]    = odd && (syn == POS);
  end

  always_comb begin
    wr_ham = '0;
    rd_ham = '0;
    for (int i = 0; i < DATA_W; i++) begin
      wr_ham = wr_ham ^ wr_term[i];
      rd_ham = rd_ham ^ rd_term[i];
    end
  end

  assign enc_check = {(^enc_data) ^ (^wr_ham), wr_ham};

  assign syn      = rd_ham ^ rd_check[P-1:0];
  assign odd      = (^rd_data) ^ (^rd_check);
  assign chk_only = (syn & (syn - 1'b1)) == '0;
  assign fixed    = odd && ((|flip) || chk_only);
  assign unfix    = (!odd && syn != '0) || (odd && !(|flip) && !chk_only);

  logic new_fix, new_unf;
  assign new_fix = rd_req && ecc_on && fixed;
  assign new_unf = rd_req && ecc_on && unfix;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_data       <= '0;
      out_check      <= '0;
      err_irq        <= 1'b0;
      flag_fixed     <= 1'b0;
      flag_unfixable <= 1'b0;
    end else begin
      out_valid      <= rd_req;
      err_irq        <= new_fix || new_unf;
      flag_fixed     <= (flag_fixed && !clr_fixed) || new_fix;
      flag_unfixable <= (flag_unfixable && !clr_unfixable) || new_unf;
      if (rd_req) begin
        out_data  <= ecc_on ? (rd_data ^ flip) : rd_data;
        out_check <= rd_check;
      end
    end
  end

endmodule

// File: rtl/row_secded_chk.sv
module row_secded_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ecc_on,
  input logic              rd_req,
  input logic [DATA_W-1:0] rd_data,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              err_irq,
  input logic              flag_fixed,
  input logic              flag_unfixable,
  input logic              clr_fixed,
  input logic              clr_unfixable
);

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> out_valid);
  p_valid_only_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !out_valid);
  p_irq_with_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> out_valid && (flag_fixed || flag_unfixable));
  p_fix_rise_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_fixed) |-> err_irq);
  p_unf_rise_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_unfixable) |-> err_irq);
  p_fix_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_fixed && !clr_fixed |=> flag_fixed);
  p_unf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_unfixable && !clr_unfixable |=> flag_unfixable);
  p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !ecc_on |=> !err_irq);
  p_off_raw_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !ecc_on |=> out_data == $past(rd_data));

endmodule

bind row_secded row_secded_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ecc_on(ecc_on), .rd_req(rd_req), .rd_data(rd_data),
  .out_valid(out_valid), .out_data(out_data), .err_irq(err_irq),
  .flag_fixed(flag_fixed), .flag_unfixable(flag_unfixable),
  .clr_fixed(clr_fixed), .clr_unfixable(clr_unfixable)
);

// File: tb/sim_row_secded.sv
module sim_row_secded;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, ecc_on = 1'b1, rd_req = 1'b0;
  logic [63:0] rd_data = '0, enc_data = '0;
  logic [7:0] rd_check = '0;
  logic clr_fixed = 1'b0, clr_unfixable = 1'b0;
  logic out_valid, err_irq, flag_fixed, flag_unfixable;
  logic [63:0] out_data;
  logic [7:0] out_check, enc_check;

  row_secded u0 (.*);

  int total = 0, bad = 0;
  int pos [64];

  typedef struct { logic [63:0] d; logic [7:0] c; logic irq; string req; } exp_t;
  exp_t q[$];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_enc(input logic [63:0] d);
    logic [6:0] h = '0;
    for (int i = 0; i < 64; i++) if (d[i]) h ^= 7'(pos[i]);
    return {(^d) ^ (^h), h};
  endfunction

  task automatic rd(input logic [63:0] d, input logic [7:0] c, input logic en,
                    input logic [63:0] ed, input logic eirq, input string req);
    @(negedge clk);
    rd_req = 1'b1; rd_data = d; rd_check = c; ecc_on = en;
    q.push_back('{ed, c, eirq, req});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd_req = 1'b0; clr_fixed = 1'b0; clr_unfixable = 1'b0;
    end
  endtask

  task automatic clear_both();
    @(negedge clk);
    rd_req = 1'b0; clr_fixed = 1'b1; clr_unfixable = 1'b1;
    idle(1);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        exp_t e;
        if (q.size() == 0) chk("R2 unexpected valid", 1, 0);
        else begin
          e = q.pop_front();
          chk({e.req, " data"}, out_data, e.d);
          chk("R10 check byte", 64'(out_check), 64'(e.c));
          chk("R7 irq", 64'(err_irq), 64'(e.irq));
        end
      end else if (err_irq) chk("R7 irq without valid", 1, 0);
    end
  end

  function automatic logic [71:0] cw(input logic [63:0] d);
    return {model_enc(d), d};
  endfunction

  initial begin
    int n = 0;
    for (int p = 1; p < 128 && n < 64; p++)
      if ((p & (p - 1)) != 0) begin pos[n] = p; n++; end
  end

  bit done = 0;
  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] pats [4];
    logic [71:0] w;
    pats[0] = 64'h0; pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[2] = 64'hDEAD_BEEF_0123_4567; pats[3] = 64'h8000_0000_0000_0001;

    #20;
    chk("R11 valid", 64'(out_valid), 0);
    chk("R11 irq", 64'(err_irq), 0);
    chk("R11 flags", 64'({flag_fixed, flag_unfixable}), 0);
    chk("R11 data", out_data, 0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < 4; i++) begin
      @(negedge clk); enc_data = pats[i]; #1;
      chk("R1 encoder", 64'(enc_check), 64'(model_enc(pats[i])));
    end

    for (int i = 0; i < 4; i++) rd(pats[i], model_enc(pats[i]), 1, pats[i], 0, "R3 clean");
    rd(pats[2], model_enc(pats[2]), 1, pats[2], 0, "R3 clean b2b");
    idle(2);
    chk("R2 idle valid", 64'(out_valid), 0);
    chk("R3 no flags", 64'({flag_fixed, flag_unfixable}), 0);

    foreach (pats[k]) begin
      int bits [3] = '{0, 37, 63};
      foreach (bits[j]) begin
        w = cw(pats[k]); w[bits[j]] = ~w[bits[j]];
        rd(w[63:0], w[71:64], 1, pats[k], 1, "R4 data bit fix");
      end
    end
    idle(2);
    chk("R4 fixed flag", 64'(flag_fixed), 1);
    chk("R4 unfix flag", 64'(flag_unfixable), 0);
    @(negedge clk); clr_fixed = 1'b1;
    idle(1);
    chk("R8 clear fixed", 64'(flag_fixed), 0);

    w = cw(pats[2]); w[67] = ~w[67];
    rd(w[63:0], w[71:64], 1, pats[2], 1, "R5 hamming bit");
    w = cw(pats[3]); w[71] = ~w[71];
    rd(w[63:0], w[71:64], 1, pats[3], 1, "R5 parity bit");
    idle(2);
    chk("R5 fixed flag", 64'(flag_fixed), 1);
    chk("R5 unfix flag", 64'(flag_unfixable), 0);
    clear_both();

    w = cw(pats[2]); w[5] = ~w[5]; w[20] = ~w[20];
    rd(w[63:0], w[71:64], 1, w[63:0], 1, "R6 two data bits");
    w = cw(pats[1]); w[9] = ~w[9]; w[66] = ~w[66];
    rd(w[63:0], w[71:64], 1, w[63:0], 1, "R6 data+check");
    idle(2);
    chk("R6 unfix flag", 64'(flag_unfixable), 1);
    chk("R6 fixed flag untouched", 64'(flag_fixed), 0);
    idle(3);
    chk("R8 sticky hold", 64'(flag_unfixable), 1);

    w = cw(pats[0]); w[1] = ~w[1]; w[70] = ~w[70];
    rd(w[63:0], w[71:64], 1, w[63:0], 1, "R8 set vs clear");
    clr_unfixable = 1'b1;
    idle(1);
    chk("R8 set wins", 64'(flag_unfixable), 1);
    clear_both();
    chk("R8 cleared", 64'(flag_unfixable), 0);

    w = cw(pats[2]); w[12] = ~w[12];
    rd(w[63:0], w[71:64], 0, w[63:0], 0, "R9 off single");
    w = cw(pats[2]); w[3] = ~w[3]; w[40] = ~w[40];
    rd(w[63:0], 8'h5A, 0, w[63:0], 0, "R9 off storage");
    idle(2);
    chk("R9 flags untouched", 64'({flag_fixed, flag_unfixable}), 0);
    chk("R2 queue drained", 64'(q.size()), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule